// File: doc/BRIEF.md
# Ethernet Link Bring-Up Sequencer

This controller takes an Ethernet port from a cold or faulted state into data mode. It holds the port core, the negotiation/training logic and the reconfiguration path in reset. It waits for the configuration to finish loading and for the core to acknowledge the reset. It then releases all three resets and steps through a fixed series of readiness conditions. Traffic is allowed only once the last condition has been met, which the block signals by raising a single link-ready output.

Each waiting stage has a programmable cycle budget. If a stage overruns that budget, the sequencer records which stage failed in a sticky error flag and starts again from reset. Once the link is up, losing either transmit-lane stability or receive PCS readiness drops link-ready on the next cycle and restarts the sequence. A 4-bit stage code is always visible, so the surrounding logic can tell where bring-up has stalled.

Top module: `link_bringup_seq`

## Requirements
- R1: While `rst_ni` is low the block sits in stage 1 (RESET) with all three reset outputs high, `link_ready_o` low and `err_o` low. RESET lasts one cycle and is then followed by stage 2.
- R2: `core_rst_o`, `anlt_rst_o` and `reconfig_rst_o` are high in stages 1, 2 and 3 and low in stages 4 to 8.
- R3: Stage 2 (CFG) advances to stage 3 on the first clock edge at which `cfg_loaded_i` is 1. Until then it stays in stage 2.
- R4: Stage 3 (ACK) advances to stage 4 only on a clock edge at which the active-low `rst_ack_ni` is 0.
- R5: Stage 4 (AN) advances to stage 5 when `an_done_i` is 1. Stage 5 (LT) advances to stage 6 when `lt_done_i` is 1. `lt_done_i` has no effect while in stage 4.
- R6: Stage 6 (TX) advances to stage 7 when `tx_lanes_stable_i` is 1, and `rx_pcs_ready_i` has no effect there. Stage 7 (RX) advances to stage 8 (UP) when `rx_pcs_ready_i` is 1. `link_ready_o` is high exactly in stage 8.
- R7: In stage 8, a clock edge at which `tx_lanes_stable_i` or `rx_pcs_ready_i` is 0 moves the block to stage 1. `link_ready_o` is then low from the next cycle.
- R8: `stage_o` encodes the current stage as RESET=1, CFG=2, ACK=3, AN=4, LT=5, TX=6, RX=7, UP=8.
- R9: With `timeout_i` = N > 0, a wait stage (2 to 7) whose condition is still unmet at the N-th clock edge after entry returns to stage 1. At that same edge `err_o` goes high and `err_stage_o` takes that stage's code. `err_o` stays high until `rst_ni`. `timeout_i` = 0 disables the timeout.
- R10: `rst_req_i` or `reconfig_req_i` high at a clock edge moves the block to stage 1 from any stage. It stays there while either request is held, and no error is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Global reset request, restarts the sequence |
| reconfig_req_i | input | 1 | Reconfiguration reset request, restarts the sequence |
| timeout_i | input | TMO_W | Per-stage cycle budget, 0 disables it |
| cfg_loaded_i | input | 1 | Configuration load finished |
| rst_ack_ni | input | 1 | Reset acknowledge, active low |
| an_done_i | input | 1 | Auto-negotiation complete |
| lt_done_i | input | 1 | Link training complete |
| tx_lanes_stable_i | input | 1 | Transmit lanes stable |
| rx_pcs_ready_i | input | 1 | Receive PCS ready |
| core_rst_o | output | 1 | Reset to the MAC/PCS core |
| anlt_rst_o | output | 1 | Reset to negotiation/training logic |
| reconfig_rst_o | output | 1 | Reconfiguration reset |
| link_ready_o | output | 1 | Traffic may start |
| stage_o | output | 4 | Current stage code |
| err_o | output | 1 | Sticky timeout flag |
| err_stage_o | output | 4 | Stage code of the latest timeout |

## Verification
The bench raises later conditions early, such as training done during negotiation or RX ready during the TX wait. A sequencer that tested its conditions out of order would then skip a stage. It drops RX and then TX while the link is up. A design that latched link-ready or checked only one of the two signals would keep traffic enabled. It lets training overrun a short budget and counts the exact cycle of the return to reset and the recorded stage code, where an off-by-one counter or a counter not cleared on stage entry shows up at once. It also holds CFG for hundreds of cycles with a zero budget, which would expose a timeout that is not disabled by zero.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

  typedef enum logic [3:0] {
    ST_RESET = 4'd1,
    ST_CFG   = 4'd2,
    ST_ACK   = 4'd3,
    ST_AN    = 4'd4,
    ST_LT    = 4'd5,
    ST_TX    = 4'd6,
    ST_RX    = 4'd7,
    ST_UP    = 4'd8
  } stage_e;

  function automatic logic is_wait(stage_e s);
    return (s == ST_CFG) || (s == ST_ACK) || (s == ST_AN) ||
           (s == ST_LT)  || (s == ST_TX)  || (s == ST_RX);
  endfunction

  function automatic logic holds_reset(stage_e s);
    return (s == ST_RESET) || (s == ST_CFG) || (s == ST_ACK);
  endfunction

endpackage

// File: rtl/bringup_stage_timer.sv
module bringup_stage_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] CntMax = '1;

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  // expire on the limit-th edge spent in the stage
  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

  // an expiry always forces a stage change, so the count restarts
  a_r9_expire_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/bringup_err_latch.sv
module bringup_err_latch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic [3:0] code_i,
  output logic       err_o,
  output logic [3:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      code_o <= '0;
    end else if (set_i) begin
      err_o  <= 1'b1;
      code_o <= code_i;
    end
  end

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r9_code_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (code_o == $past(code_i)));

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import link_bringup_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   restart_i,
  input  logic   expire_i,
  input  logic   cfg_loaded_i,
  input  logic   rst_ack_ni,
  input  logic   an_done_i,
  input  logic   lt_done_i,
  input  logic   tx_stable_i,
  input  logic   rx_ready_i,
  output stage_e stage_o,
  output logic   waiting_o,
  output logic   advance_o,
  output logic   timeout_o
);
  stage_e state_q, state_d;
  logic   cond;

  assign waiting_o = is_wait(state_q);

  always_comb begin
    cond = 1'b0;
    unique case (state_q)
      ST_CFG:  cond = cfg_loaded_i;
      ST_ACK:  cond = !rst_ack_ni;
      ST_AN:   cond = an_done_i;
      ST_LT:   cond = lt_done_i;
      ST_TX:   cond = tx_stable_i;
      ST_RX:   cond = rx_ready_i;
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    timeout_o = 1'b0;
    if (state_q == ST_RESET) begin
      state_d = ST_CFG;
    end else if (state_q == ST_UP) begin
      if (!(tx_stable_i && rx_ready_i)) state_d = ST_RESET;
    end else if (waiting_o) begin
      if (cond) begin
        state_d = stage_e'(4'(state_q) + 4'd1);
      end else if (expire_i) begin
        state_d   = ST_RESET;
        timeout_o = 1'b1;
      end
    end else begin
      state_d = ST_RESET;
    end
    if (restart_i) begin
      state_d   = ST_RESET;
      timeout_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign stage_o   = state_q;
  assign advance_o = (state_d != state_q);

  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == ST_RESET));

  a_r4_ack_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AN && $past(state_q) == ST_ACK) |-> !$past(rst_ack_ni));

  a_r5_an_before_lt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LT && $past(state_q) == ST_AN) |-> $past(an_done_i));

  a_r8_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (4'(state_q) >= 4'd1) && (4'(state_q) <= 4'd8));

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import link_bringup_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_req_i,
  input  logic             reconfig_req_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             cfg_loaded_i,
  input  logic             rst_ack_ni,
  input  logic             an_done_i,
  input  logic             lt_done_i,
  input  logic             tx_lanes_stable_i,
  input  logic             rx_pcs_ready_i,
  output logic             core_rst_o,
  output logic             anlt_rst_o,
  output logic             reconfig_rst_o,
  output logic             link_ready_o,
  output logic [3:0]       stage_o,
  output logic             err_o,
  output logic [3:0]       err_stage_o
);
  stage_e stage;
  logic   waiting, advance, timeout, expire, restart;

  assign restart = rst_req_i | reconfig_req_i;

  bringup_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .expire_i     (expire),
    .cfg_loaded_i (cfg_loaded_i),
    .rst_ack_ni   (rst_ack_ni),
    .an_done_i    (an_done_i),
    .lt_done_i    (lt_done_i),
    .tx_stable_i  (tx_lanes_stable_i),
    .rx_ready_i   (rx_pcs_ready_i),
    .stage_o      (stage),
    .waiting_o    (waiting),
    .advance_o    (advance),
    .timeout_o    (timeout)
  );

  bringup_stage_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (advance),
    .run_i    (waiting),
    .limit_i  (timeout_i),
    .expire_o (expire)
  );

  bringup_err_latch u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (timeout),
    .code_i (4'(stage)),
    .err_o  (err_o),
    .code_o (err_stage_o)
  );

  assign core_rst_o     = holds_reset(stage);
  assign anlt_rst_o     = holds_reset(stage);
  assign reconfig_rst_o = holds_reset(stage);
  assign link_ready_o   = (stage == ST_UP);
  assign stage_o        = 4'(stage);

  a_r6_up_needs_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ready_o) |-> $past(rx_pcs_ready_i));

  a_r7_drop_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ready_o && !(tx_lanes_stable_i && rx_pcs_ready_i)) |=>
      (!link_ready_o && stage_o == 4'd1));

  a_r2_released_when_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_ready_o |-> (!core_rst_o && !anlt_rst_o && !reconfig_rst_o));

  a_r10_no_err_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !err_o) |=> !err_o);

endmodule

// File: tb/tb_link_bringup_seq.sv
`timescale 1ns/1ps
module tb_link_bringup_seq;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, rst_req, reconfig_req, cfg, ack_n, an, lt, tx, rx;
  logic [TMO_W-1:0] tmo;
  logic core_rst, anlt_rst, reconfig_rst, link_ready, err;
  logic [3:0] stage, err_stage;

  link_bringup_seq #(.TMO_W(TMO_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req), .reconfig_req_i(reconfig_req),
    .timeout_i(tmo), .cfg_loaded_i(cfg), .rst_ack_ni(ack_n), .an_done_i(an),
    .lt_done_i(lt), .tx_lanes_stable_i(tx), .rx_pcs_ready_i(rx),
    .core_rst_o(core_rst), .anlt_rst_o(anlt_rst), .reconfig_rst_o(reconfig_rst),
    .link_ready_o(link_ready), .stage_o(stage), .err_o(err), .err_stage_o(err_stage)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_stage, m_cnt, m_err_stage;
  bit m_err;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stage = 1; m_cnt = 0; m_err = 0; m_err_stage = 0;
    end else begin
      int nxt;
      bit c, w;
      nxt = m_stage;
      w = (m_stage >= 2 && m_stage <= 7);
      case (m_stage)
        2: c = cfg;  3: c = !ack_n; 4: c = an;
        5: c = lt;   6: c = tx;     7: c = rx;
        default: c = 0;
      endcase
      if (rst_req || reconfig_req) nxt = 1;
      else if (m_stage == 1) nxt = 2;
      else if (m_stage == 8) begin
        if (!(tx && rx)) nxt = 1;
      end else if (c) nxt = m_stage + 1;
      else if (tmo != 0 && m_cnt == int'(tmo) - 1) begin
        nxt = 1; m_err = 1; m_err_stage = m_stage;
      end
      if (nxt != m_stage) m_cnt = 0;
      else if (w) m_cnt++;
      m_stage = nxt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(int'(stage) == m_stage, "R8 stage", stage, m_stage);
      chk(link_ready == (m_stage == 8), "R6 link_ready", link_ready, m_stage == 8);
      chk(core_rst == (m_stage <= 3) && anlt_rst == (m_stage <= 3) &&
          reconfig_rst == (m_stage <= 3), "R2 resets", core_rst, m_stage <= 3);
      chk(err == m_err, "R9 err", err, m_err);
      chk(int'(err_stage) == m_err_stage, "R9 err_stage", err_stage, m_err_stage);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_ni = 0; rst_req = 0; reconfig_req = 0; tmo = 16'd200;
    cfg = 0; ack_n = 1; an = 0; lt = 0; tx = 0; rx = 0;
    step(3);
    chk(stage == 4'd1 && core_rst && !link_ready && !err, "R1 reset state", stage, 1);
    rst_ni = 1;
    step(1); chk(stage == 4'd2, "R1 reset lasts one cycle", stage, 2);
    step(5); chk(stage == 4'd2, "R3 waits for cfg", stage, 2);
    cfg = 1;
    step(1); chk(stage == 4'd3 && core_rst, "R3 cfg advances", stage, 3);
    step(4); chk(stage == 4'd3, "R4 waits for ack low", stage, 3);
    ack_n = 0;
    step(1); chk(stage == 4'd4 && !core_rst && !anlt_rst && !reconfig_rst, "R2 release", stage, 4);
    lt = 1;
    step(3); chk(stage == 4'd4, "R5 lt ignored in AN", stage, 4);
    an = 1;
    step(1); chk(stage == 4'd5, "R5 an advances", stage, 5);
    step(1); chk(stage == 4'd6, "R5 lt advances", stage, 6);
    rx = 1;
    step(2); chk(stage == 4'd6 && !link_ready, "R6 rx ignored in TX", stage, 6);
    tx = 1;
    step(1); chk(stage == 4'd7 && !link_ready, "R6 RX stage", stage, 7);
    step(1); chk(link_ready == 1'b1 && stage == 4'd8, "R6 link up", link_ready, 1);
    step(5); chk(link_ready == 1'b1, "R6 link holds", link_ready, 1);
    rx = 0;
    step(1); chk(!link_ready && stage == 4'd1, "R7 rx loss", stage, 1);
    step(7); chk(stage == 4'd7, "R7 back in RX wait", stage, 7);
    rx = 1;
    step(1); chk(link_ready == 1'b1, "R7 relink", link_ready, 1);
    tx = 0;
    step(1); chk(!link_ready && stage == 4'd1, "R7 tx loss", stage, 1);
    tx = 1;
    step(4);
    rst_req = 1;
    step(1); chk(stage == 4'd1, "R10 global req", stage, 1);
    step(3); chk(stage == 4'd1 && !err, "R10 held in reset", stage, 1);
    rst_req = 0;
    step(3);
    reconfig_req = 1;
    step(1); chk(stage == 4'd1, "R10 reconfig req", stage, 1);
    reconfig_req = 0;
    // timeout during LT
    lt = 0; tmo = 16'd8;
    rst_req = 1; step(1); rst_req = 0;
    step(11); chk(stage == 4'd5 && !err, "R9 before expiry", stage, 5);
    step(1); chk(stage == 4'd1 && err && err_stage == 4'd5, "R9 expiry", err_stage, 5);
    lt = 1;
    step(10); chk(link_ready && err, "R9 sticky after relink", err, 1);
    // zero disables
    tmo = '0; cfg = 0;
    rst_req = 1; step(1); rst_req = 0;
    step(300); chk(stage == 4'd2 && err_stage == 4'd5, "R9 zero disables", stage, 2);
    finish_run();
  end
endmodule